// File: doc/BRIEF.md
# DMA Logical-to-Physical Page Translator

This block sits between DMA engines and the memory system and turns 24-bit logical DMA addresses into 29-bit physical addresses. The logical space is cut into 4 KB pages. The upper twelve bits of a logical address select one entry of a single-level page table that lives in system memory, and the low twelve bits travel through untouched as the offset within the page. Software places the table anywhere in physical memory and tells the block where it sits and how many bytes it covers. Each entry is 8 bytes, and the frame comes from its first word.

Recent translations are kept in a four-way fully associative cache. A request that hits is answered one cycle after it is accepted. A request that misses issues a single read of the table entry over a valid/ready read port and stalls further requests until the entry returns. The returned frame then answers the request and is installed in the cache. A request whose entry would lie at or beyond the table's byte limit is refused with an address error and causes no memory traffic. Cached translations survive until software writes the invalidate register.

Top module: `dma_xlate`

## Requirements
- R1: A request (`req_valid && req_ready`) whose page is cached and in bounds produces, on the next cycle, `rsp_valid=1`, `rsp_err=0` and `rsp_paddr = {cached frame, laddr[11:0]}`, with no memory read. Each response lasts exactly one cycle.
- R2: When `laddr[23:12]*8 >= limit`, the next cycle shows `rsp_valid=1`, `rsp_err=1`, `rsp_paddr=0` and no memory read. This check takes precedence over a cached entry for the same page.
- R3: On a miss, `mem_rd_valid` rises on the next cycle with `mem_rd_addr = base + laddr[23:12]*8` (modulo 2^29). It stays asserted with a stable address until the cycle in which `mem_rd_ready` is high.
- R4: The frame is `mem_rdata[28:12]`; read-data bits 31:29 and 11:0 are ignored. The response `{frame, offset}` appears the cycle after `mem_rdata_valid` is sampled.
- R5: `req_ready` is low from the cycle after a miss is accepted until the cycle after its response. Exactly one memory read is issued per miss.
- R6: A page that is fetched and not invalidated during its miss is answered as a hit on its next request.
- R7: The cache holds 4 pages and replaces them in round-robin order. The replacement pointer advances once per fill and is not reset by an invalidate.
- R8: Any write with `cfg_sel=2` discards every cached page, whatever the data. The next request to any page misses.
- R9: An invalidate written while a miss is outstanding still lets that miss respond with the fetched frame, but the frame is not installed in the cache.
- R10: A write with `cfg_sel=0` loads the table base from `cfg_wdata[28:0]`, and one with `cfg_sel=1` loads the 32-bit byte limit. After reset: base 0, limit 0x8000, `req_ready=1`, `rsp_valid=0`, `mem_rd_valid=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 limit, 2 invalidate |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | 24 | Logical address to translate |
| rsp_valid | output | 1 | Response valid (one cycle) |
| rsp_err | output | 1 | Address error (beyond table limit) |
| rsp_paddr | output | 29 | Translated physical address |
| mem_rd_valid | output | 1 | Table-entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 29 | Physical address of the table entry |
| mem_rdata_valid | input | 1 | Read data returned |
| mem_rdata | input | 32 | First word of the table entry |

## Verification
The hardest case to reach is an invalidate that lands while a table read is in flight. Software must write the register in the narrow window between the miss being accepted and the data coming back, and the only visible effect is that a later request to the same page misses. The bench plays the memory itself, so it can place the invalidate write in the very cycle the read handshake completes. It then requests the same page again and expects a fresh read. Round-robin eviction is driven with five distinct pages, followed by re-requests that separate the evicted slot from the survivors. During every miss the bench also keeps presenting a second request, to show that it is held off.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_ISSUE = 2'd1,
    FS_WAIT  = 2'd2
  } fetch_state_t;

  localparam logic [1:0] SEL_BASE  = 2'd0;
  localparam logic [1:0] SEL_LIMIT = 2'd1;
  localparam logic [1:0] SEL_INVAL = 2'd2;

endpackage

// File: rtl/dma_xlate_cache.sv
module dma_xlate_cache #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 12,
  parameter int FRAME_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  input  logic               fill_en,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               flush
);

  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] dup_vec;
  logic [ENTRIES-1:0] wr_en;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
      assign dup_vec[g] = vld_q[g] && (tag_q[g] == fill_tag);
      assign wr_en[g]   = fill_en && !flush && (ptr_q == PTR_W'(g));
    end
  endgenerate

  always_comb begin
    lk_frame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) lk_frame = lk_frame | frame_q[i];
    end
  end

  assign lk_hit = |hit_vec;

  always_comb begin
    vld_d = vld_q;
    ptr_d = ptr_q;
    if (flush) begin
      vld_d = '0;
    end else if (fill_en) begin
      vld_d[ptr_q] = 1'b1;
      ptr_d = (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_en[i]) begin
        tag_q[i]   <= fill_tag;
        frame_q[i] <= fill_frame;
      end
    end
  end

  // A page may sit in at most one slot.
  assert_hit_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // A fill only follows a miss, so its page must not already be cached.
  assert_fill_unique_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !(|dup_vec));

endmodule

// File: rtl/dma_xlate_fetch.sv
module dma_xlate_fetch
  import dma_xlate_pkg::*;
#(
  parameter int ADDR_W = 29,
  parameter int DATA_W = 32,
  parameter int PAGE_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        start_addr,
  input  logic                     flush,
  output logic                     busy,
  output logic                     mem_rd_valid,
  input  logic                     mem_rd_ready,
  output logic [ADDR_W-1:0]        mem_rd_addr,
  input  logic                     mem_rdata_valid,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic                     done,
  output logic [ADDR_W-PAGE_W-1:0] done_frame,
  output logic                     done_keep
);

  localparam int FRAME_W = ADDR_W - PAGE_W;

  fetch_state_t      state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              stale_q, stale_d;
  logic              unused_rdata_bits;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    stale_d = stale_q;
    done    = 1'b0;
    case (state_q)
      FS_IDLE: begin
        if (start) begin
          state_d = FS_ISSUE;
          addr_d  = start_addr;
          stale_d = 1'b0;
        end
      end
      FS_ISSUE: begin
        if (flush) stale_d = 1'b1;
        if (mem_rd_ready) state_d = FS_WAIT;
      end
      FS_WAIT: begin
        if (flush) stale_d = 1'b1;
        if (mem_rdata_valid) begin
          done    = 1'b1;
          state_d = FS_IDLE;
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      addr_q  <= '0;
      stale_q <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      stale_q <= stale_d;
    end
  end

  assign busy         = (state_q != FS_IDLE);
  assign mem_rd_valid = (state_q == FS_ISSUE);
  assign mem_rd_addr  = addr_q;
  assign done_frame   = mem_rdata[PAGE_W +: FRAME_W];
  assign done_keep    = !stale_q && !flush;
  assign unused_rdata_bits = ^{mem_rdata[DATA_W-1:ADDR_W], mem_rdata[PAGE_W-1:0]};

  // A read request is held, with a stable address, until memory takes it.
  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // Only one read per miss: after the handshake no further request.
  assert_one_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid);

endmodule

// File: rtl/dma_xlate.sv
module dma_xlate
  import dma_xlate_pkg::*;
#(
  parameter int          LADDR_W     = 24,
  parameter int          PADDR_W     = 29,
  parameter int          PAGE_W      = 12,
  parameter int          DATA_W      = 32,
  parameter int          ENTRIES     = 4,
  parameter int          ENTRY_LOG2  = 3,
  parameter logic [31:0] LIMIT_RESET = 32'h0000_8000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LADDR_W-1:0] req_laddr,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [PADDR_W-1:0] rsp_paddr,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [PADDR_W-1:0] mem_rd_addr,
  input  logic               mem_rdata_valid,
  input  logic [DATA_W-1:0]  mem_rdata
);

  localparam int IDX_W   = LADDR_W - PAGE_W;
  localparam int FRAME_W = PADDR_W - PAGE_W;
  localparam int EOFS_W  = IDX_W + ENTRY_LOG2;

  logic [PADDR_W-1:0] base_q, base_d;
  logic [DATA_W-1:0]  limit_q, limit_d;
  logic               flush;

  logic [IDX_W-1:0]   req_idx;
  logic [PAGE_W-1:0]  req_ofs;
  logic [EOFS_W-1:0]  ent_ofs;
  logic [PADDR_W-1:0] ent_addr;
  logic               oob;
  logic               accept;
  logic               miss_start;

  logic               lk_hit;
  logic [FRAME_W-1:0] lk_frame;

  logic               busy;
  logic               f_done;
  logic [FRAME_W-1:0] f_frame;
  logic               f_keep;

  logic [IDX_W-1:0]   pend_tag_q, pend_tag_d;
  logic [PAGE_W-1:0]  pend_ofs_q, pend_ofs_d;

  logic               rsp_v_d, rsp_e_d;
  logic [PADDR_W-1:0] rsp_pa_d;

  // configuration registers
  assign flush = cfg_we && (cfg_sel == SEL_INVAL);

  always_comb begin
    base_d  = base_q;
    limit_d = limit_q;
    if (cfg_we && cfg_sel == SEL_BASE)  base_d  = cfg_wdata[PADDR_W-1:0];
    if (cfg_we && cfg_sel == SEL_LIMIT) limit_d = cfg_wdata;
  end

  // request decode and bound check
  assign req_idx    = req_laddr[LADDR_W-1:PAGE_W];
  assign req_ofs    = req_laddr[PAGE_W-1:0];
  assign ent_ofs    = {req_idx, {ENTRY_LOG2{1'b0}}};
  assign ent_addr   = base_q + PADDR_W'(ent_ofs);
  assign oob        = (DATA_W'(ent_ofs) >= limit_q);
  assign req_ready  = !busy;
  assign accept     = req_valid && req_ready;
  assign miss_start = accept && !oob && !lk_hit;

  dma_xlate_cache #(
    .ENTRIES (ENTRIES),
    .TAG_W   (IDX_W),
    .FRAME_W (FRAME_W)
  ) u_cache (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_tag     (req_idx),
    .lk_hit     (lk_hit),
    .lk_frame   (lk_frame),
    .fill_en    (f_done && f_keep),
    .fill_tag   (pend_tag_q),
    .fill_frame (f_frame),
    .flush      (flush)
  );

  dma_xlate_fetch #(
    .ADDR_W (PADDR_W),
    .DATA_W (DATA_W),
    .PAGE_W (PAGE_W)
  ) u_fetch (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (miss_start),
    .start_addr      (ent_addr),
    .flush           (flush),
    .busy            (busy),
    .mem_rd_valid    (mem_rd_valid),
    .mem_rd_ready    (mem_rd_ready),
    .mem_rd_addr     (mem_rd_addr),
    .mem_rdata_valid (mem_rdata_valid),
    .mem_rdata       (mem_rdata),
    .done            (f_done),
    .done_frame      (f_frame),
    .done_keep       (f_keep)
  );

  // pending miss context and response
  always_comb begin
    pend_tag_d = pend_tag_q;
    pend_ofs_d = pend_ofs_q;
    if (miss_start) begin
      pend_tag_d = req_idx;
      pend_ofs_d = req_ofs;
    end
  end

  always_comb begin
    rsp_v_d  = 1'b0;
    rsp_e_d  = 1'b0;
    rsp_pa_d = '0;
    if (f_done) begin
      rsp_v_d  = 1'b1;
      rsp_pa_d = {f_frame, pend_ofs_q};
    end else if (accept && oob) begin
      rsp_v_d  = 1'b1;
      rsp_e_d  = 1'b1;
    end else if (accept && lk_hit) begin
      rsp_v_d  = 1'b1;
      rsp_pa_d = {lk_frame, req_ofs};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      limit_q    <= LIMIT_RESET;
      pend_tag_q <= '0;
      pend_ofs_q <= '0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_paddr  <= '0;
    end else begin
      base_q     <= base_d;
      limit_q    <= limit_d;
      pend_tag_q <= pend_tag_d;
      pend_ofs_q <= pend_ofs_d;
      rsp_valid  <= rsp_v_d;
      rsp_err    <= rsp_e_d;
      rsp_paddr  <= rsp_pa_d;
    end
  end

  // A cached, in-bounds request answers next cycle without touching memory.
  assert_hit_noread_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lk_hit && !oob) |=> (rsp_valid && !rsp_err && !mem_rd_valid));

  // An out-of-bounds request errors next cycle and issues no read.
  assert_oob_noread_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && oob) |=> (rsp_valid && rsp_err && !mem_rd_valid));

  // While a table read is outstanding no new request is accepted.
  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready);

endmodule

// File: tb/sim_dma_xlate.sv
`timescale 1ns/1ps
module sim_dma_xlate;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_laddr;
  logic        rsp_valid;
  logic        rsp_err;
  logic [28:0] rsp_paddr;
  logic        mem_rd_valid;
  logic        mem_rd_ready;
  logic [28:0] mem_rd_addr;
  logic        mem_rdata_valid;
  logic [31:0] mem_rdata;

  dma_xlate u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_paddr(rsp_paddr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rdata_valid(mem_rdata_valid), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural reference state
  logic [28:0] m_base;
  logic [31:0] m_limit;
  int          m_ptr;
  logic [11:0] m_tag [4];
  logic [16:0] m_frm [4];
  bit          m_vld [4];

  function automatic logic [16:0] mem_frame(input logic [28:0] a);
    return a[19:3] ^ 17'h1ACE5;
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic model_flush();
    for (int i = 0; i < 4; i++) m_vld[i] = 0;
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 2'd0) m_base = d[28:0];
    if (sel == 2'd1) m_limit = d;
    if (sel == 2'd2) model_flush();
  endtask

  task automatic do_req(input string rq, input logic [23:0] la, input bit inv_mid,
                        input int lr, input int ld);
    logic [11:0] idx;
    logic [28:0] ea;
    logic [16:0] fr;
    bit          oob;
    int          hs;
    idx = la[23:12];
    @(negedge clk);
    chk(rq, "ready when idle", {31'b0, req_ready}, 32'd1);
    chk(rq, "no lingering response (R1)", {31'b0, rsp_valid}, 32'd0);
    req_valid = 1'b1; req_laddr = la;
    oob = ({17'b0, idx, 3'b0} >= m_limit);
    hs = -1;
    for (int i = 0; i < 4; i++) if (m_vld[i] && m_tag[i] == idx) hs = i;
    @(negedge clk);
    if (oob) begin
      req_valid = 1'b0;
      chk(rq, "err rsp_valid (R2)", {31'b0, rsp_valid}, 32'd1);
      chk(rq, "err flag (R2)", {31'b0, rsp_err}, 32'd1);
      chk(rq, "err paddr (R2)", {3'b0, rsp_paddr}, 32'd0);
      chk(rq, "err no read (R2)", {31'b0, mem_rd_valid}, 32'd0);
    end else if (hs >= 0) begin
      req_valid = 1'b0;
      chk(rq, "hit rsp_valid (R1)", {31'b0, rsp_valid}, 32'd1);
      chk(rq, "hit err (R1)", {31'b0, rsp_err}, 32'd0);
      chk(rq, "hit paddr (R1)", {3'b0, rsp_paddr}, {3'b0, m_frm[hs], la[11:0]});
      chk(rq, "hit no read (R1)", {31'b0, mem_rd_valid}, 32'd0);
    end else begin
      req_laddr = la ^ 24'h800000;  // competing request held during the miss
      ea = m_base + {14'b0, idx, 3'b0};
      chk(rq, "miss rd_valid (R3)", {31'b0, mem_rd_valid}, 32'd1);
      chk(rq, "miss rd_addr (R3)", {3'b0, mem_rd_addr}, {3'b0, ea});
      chk(rq, "miss stall (R5)", {31'b0, req_ready}, 32'd0);
      chk(rq, "miss no early rsp (R4)", {31'b0, rsp_valid}, 32'd0);
      for (int k = 0; k < lr; k++) begin
        @(negedge clk);
        chk(rq, "rd held (R3)", {31'b0, mem_rd_valid}, 32'd1);
        chk(rq, "rd addr stable (R3)", {3'b0, mem_rd_addr}, {3'b0, ea});
        chk(rq, "stall held (R5)", {31'b0, req_ready}, 32'd0);
      end
      mem_rd_ready = 1'b1;
      if (inv_mid) begin
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h0;
        model_flush();
      end
      @(negedge clk);
      mem_rd_ready = 1'b0; cfg_we = 1'b0;
      chk(rq, "single read (R5)", {31'b0, mem_rd_valid}, 32'd0);
      chk(rq, "stall after handshake (R5)", {31'b0, req_ready}, 32'd0);
      for (int k = 0; k < ld; k++) begin
        @(negedge clk);
        chk(rq, "no rsp before data (R4)", {31'b0, rsp_valid}, 32'd0);
        chk(rq, "no re-read (R5)", {31'b0, mem_rd_valid}, 32'd0);
        chk(rq, "stall in wait (R5)", {31'b0, req_ready}, 32'd0);
      end
      fr = mem_frame(ea);
      mem_rdata_valid = 1'b1;
      mem_rdata = {3'b111, fr, 12'hFFF};
      req_valid = 1'b0;
      @(negedge clk);
      mem_rdata_valid = 1'b0; mem_rdata = '0;
      chk(rq, "fill rsp_valid (R4)", {31'b0, rsp_valid}, 32'd1);
      chk(rq, "fill err (R4)", {31'b0, rsp_err}, 32'd0);
      chk(rq, "fill paddr (R4)", {3'b0, rsp_paddr}, {3'b0, fr, la[11:0]});
      if (!inv_mid) begin
        m_tag[m_ptr] = idx; m_frm[m_ptr] = fr; m_vld[m_ptr] = 1;
        m_ptr = (m_ptr + 1) % 4;
      end
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    req_valid = 0; req_laddr = 0; mem_rd_ready = 0; mem_rdata_valid = 0; mem_rdata = 0;
    m_base = 0; m_limit = 32'h8000; m_ptr = 0; model_flush();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "reset ready", {31'b0, req_ready}, 32'd1);
    chk("R10", "reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R10", "reset rd_valid", {31'b0, mem_rd_valid}, 32'd0);

    do_req("R3", 24'h001234, 0, 2, 1);
    do_req("R6", 24'h001ABC, 0, 0, 0);
    do_req("R10", 24'hFFF00F, 0, 0, 3);  // top page inside reset limit
    do_req("R6", 24'hFFF777, 0, 0, 0);

    cfg_write(2'd0, 32'h0100_0000);
    cfg_write(2'd2, 32'hDEAD_BEEF);
    do_req("R8", 24'h001000, 0, 1, 0);   // previously cached, must re-fetch
    do_req("R8", 24'hFFF001, 0, 0, 0);

    cfg_write(2'd1, 32'h8);
    do_req("R2", 24'h001777, 0, 0, 0);   // cached page now beyond limit
    do_req("R2", 24'h000010, 0, 0, 2);
    cfg_write(2'd1, 32'h100);
    do_req("R2", 24'h020000, 0, 0, 0);
    do_req("R2", 24'h01F321, 0, 1, 1);
    cfg_write(2'd1, 32'h8000);

    cfg_write(2'd2, 32'h0);
    do_req("R7", 24'h100001, 0, 0, 0);
    do_req("R7", 24'h101002, 0, 1, 0);
    do_req("R7", 24'h102003, 0, 0, 1);
    do_req("R7", 24'h103004, 0, 0, 0);
    do_req("R7", 24'h104005, 0, 0, 0);
    do_req("R7", 24'h101FFF, 0, 0, 0);
    do_req("R7", 24'h100006, 0, 0, 0);
    do_req("R7", 24'h101007, 0, 0, 0);
    do_req("R7", 24'h103008, 0, 0, 0);

    do_req("R9", 24'h300123, 1, 1, 1);
    do_req("R9", 24'h300456, 0, 0, 0);
    do_req("R9", 24'h300789, 0, 0, 0);
    do_req("R9", 24'h305000, 1, 0, 0);
    do_req("R9", 24'h305001, 0, 2, 2);

    repeat (2) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

endmodule